// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a serial slave on a two-wire bus (clock plus open-drain data). It gives a host controller read and write access to a small bank of 8-bit control registers. The two lines are synchronized into the system clock. START and STOP conditions are recognized on the synchronized lines, and the block pulls the data line low through an output-enable pin when it acknowledges or sends a zero.

The first byte after the slave address is a command byte. If its top bit is clear, the transfer is a block transfer: a write carries a byte count and then data for registers 0, 1, 2 and so on, and a read returns a fixed count of nine followed by the registers in ascending order. If the top bit is set, the low seven bits select one register, and a single byte is written or read. Register 0 holds a read-only bit that mirrors a live lock-status input. All registers are also presented in parallel to the surrounding logic.

A strap input chooses between two bus addresses. When the strap is low, the address byte is D2h for a write and D3h for a read. When it is high, these are D4h and D5h.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave responds only to the 7-bit address 69h when `addr_sel` is 0, or 6Ah when `addr_sel` is 1. This address sits in bits 7:1 of the first byte, and bit 0 is the direction (0 = write). For any other address it sends no acknowledge and keeps `sda_oe` low until the next START.
- R2: A command byte with bit 7 = 1 selects single-byte mode, with bits 6:0 as the register offset. A following data byte is stored in that register and shows on `regs_o[8*k +: 8]`. Registers that are not written keep their value.
- R3: In single-byte mode, a repeated START followed by the address with bit 0 = 1 returns the indexed register, MSB first.
- R4: A command byte of 00h selects block mode. The next byte from the host is a count, which is acknowledged and not otherwise used. The data bytes that follow go to registers 0, 1, 2 and onward in order.
- R5: A block-mode read returns 09h first, then registers 0, 1, 2 in ascending order for as long as the host acknowledges. It stops driving after the host's NACK.
- R6: A STOP may end a block write after any byte. Every complete byte received before it stays written, and a partly received byte is dropped.
- R7: Bit 7 of register 0 is read-only. Both in `regs_o[7]` and on reads, it shows `lock_in` delayed by one clock. Host writes to that bit have no effect.
- R8: While `rst` is high, register 0 bits 6:0 become 1Fh, register 1 becomes 2Bh, and registers 2 to 8 become 00h.
- R9: An access to an offset of 9 or above is acknowledged. The written byte is discarded and a read returns FFh.
- R10: Each byte the host sends to a matching address (address, command, count, data) is acknowledged by a low data line during the ninth clock.
- R11: A START seen at any point, including in the middle of a byte, restarts address reception from its first bit and releases `sda_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 = pull the data line low |
| addr_sel | input | 1 | Bus address strap (0: 69h, 1: 6Ah) |
| lock_in | input | 1 | Live lock status, reflected in register 0 bit 7 |
| regs_o | output | 8*NUM_REGS | Parallel register contents, register k in bits 8k+7:8k |

## Verification
The bench targets the block-mode count byte. A design that stored it would leave register 0 holding the count and shift every later byte by one. It also ends a block write in the middle of a byte with STOP; a slave that commits the partial shift register would corrupt the next register. Offsets above the bank, such as 09h and 7Fh, are accessed to expose an index that wraps onto a real register. A START is placed four bits into an address, which a byte counter that does not reset on START would misalign so that every later byte is refused. Finally, the bench writes ones into the lock bit and switches the strap, to catch a writable status bit and a fixed address.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } link_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_COUNT,
    K_DATA
  } rx_kind_e;

  // Power-up value of each register; bit 7 of register 0 is the live status bit.
  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      0:       return 8'h1F;
      1:       return 8'h2B;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= 1'b1;
          sda_pipe <= 1'b1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
          sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_pipe[TOP];
      sda_d <= sda_pipe[TOP];
    end
  end

  assign sda_s     = sda_pipe[TOP];
  assign scl_rise  = scl_pipe[TOP] & ~scl_d;
  assign scl_fall  = ~scl_pipe[TOP] & scl_d;
  assign start_det = scl_pipe[TOP] & scl_d & sda_d & ~sda_pipe[TOP];
  assign stop_det  = scl_pipe[TOP] & scl_d & ~sda_d & sda_pipe[TOP];

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lock_in,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_ptr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);

  logic [7:0] mem [NUM_REGS];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [PTR_W-1:0] SLOT = PTR_W'(i);
      localparam logic [7:0]       DEF  = reg_default(i);
      if (i == 0) begin : g_status
        // Bit 7 follows the live status input; only bits 6:0 are host-writable.
        always_ff @(posedge clk) begin
          mem[i][7] <= lock_in;
          if (rst)
            mem[i][6:0] <= DEF[6:0];
          else if (wr_en && wr_ptr == SLOT)
            mem[i][6:0] <= wr_data[6:0];
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst)
            mem[i] <= DEF;
          else if (wr_en && wr_ptr == SLOT)
            mem[i] <= wr_data;
        end
      end
      assign regs_o[i*8 +: 8] = mem[i];
    end
  endgenerate

  always_comb begin
    rd_data = 8'hFF;
    if (rd_ptr < LIMIT)
      rd_data = mem[rd_ptr[IDX_W-1:0]];
  end

endmodule

// File: rtl/smb_byte_fsm.sv
module smb_byte_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR_A      = 7'h69,
  parameter logic [6:0] ADDR_B      = 7'h6A,
  parameter logic [7:0] BLOCK_COUNT = 8'h09,
  parameter int         PTR_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic             addr_sel,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] rd_ptr
);

  link_state_e      state;
  rx_kind_e         kind;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             blk;
  logic             cnt_pend;
  logic             rw;
  logic [6:0]       my_addr;
  logic [7:0]       tx_next;

  assign my_addr = addr_sel ? ADDR_B : ADDR_A;
  assign tx_next = cnt_pend ? BLOCK_COUNT : rd_data;
  assign rd_ptr  = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      blk      <= 1'b0;
      cnt_pend <= 1'b0;
      rw       <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_ptr   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= S_RX;
        kind   <= K_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (shreg[7:1] == my_addr) begin
                    rw     <= shreg[0];
                    sda_oe <= 1'b1;
                    state  <= S_RX_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                K_CMD: begin
                  blk      <= ~shreg[7];
                  cnt_pend <= ~shreg[7];
                  ptr      <= shreg[7] ? PTR_W'(shreg[6:0]) : '0;
                  sda_oe   <= 1'b1;
                  state    <= S_RX_ACK;
                end
                K_COUNT: begin
                  sda_oe <= 1'b1;
                  state  <= S_RX_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_ptr  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                  sda_oe  <= 1'b1;
                  state   <= S_RX_ACK;
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              if (kind == K_ADDR && rw) begin
                shreg  <= tx_next;
                sda_oe <= ~tx_next[7];
                if (cnt_pend) cnt_pend <= 1'b0;
                else          ptr      <= ptr + 1'b1;
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
                case (kind)
                  K_ADDR:  kind <= K_CMD;
                  K_CMD:   kind <= blk ? K_COUNT : K_DATA;
                  default: kind <= K_DATA;
                endcase
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                state  <= S_TX_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise && sda_s) begin
              state <= S_IDLE;
            end else if (scl_fall) begin
              shreg  <= tx_next;
              sda_oe <= ~tx_next[7];
              if (cnt_pend) cnt_pend <= 1'b0;
              else          ptr      <= ptr + 1'b1;
              state  <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave #(
  parameter int         NUM_REGS    = 9,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_A      = 7'h69,
  parameter logic [6:0] ADDR_B      = 7'h6A,
  parameter logic [7:0] BLOCK_COUNT = 8'h09
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  addr_sel,
  input  logic                  lock_in,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [7:0]       wr_data, rd_data;

  smb_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_byte_fsm #(
    .ADDR_A      (ADDR_A),
    .ADDR_B      (ADDR_B),
    .BLOCK_COUNT (BLOCK_COUNT),
    .PTR_W       (PTR_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .addr_sel  (addr_sel),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .rd_ptr    (rd_ptr)
  );

  smb_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .lock_in (lock_in),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .rd_ptr  (rd_ptr),
    .rd_data (rd_data),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/smb_regbank_checker.sv
module smb_regbank_checker #(
  parameter int NUM_REGS = 9
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lock_in,
  input logic                  sda_oe,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] regs_o
);

  // R7: status bit mirrors the input one clock later
  a_r7_lock_mirror: assert property (@(posedge clk) disable iff (rst)
    regs_o[7] == $past(lock_in));

  // R8: defaults present in the cycle after reset
  a_r8_reset_defaults: assert property (@(posedge clk)
    rst |=> (regs_o[6:0] == 7'h1F && regs_o[15:8] == 8'h2B && regs_o[23:16] == 8'h00));

  // R2: registers 1 and up hold when no write strobe is issued
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_o[NUM_REGS*8-1:8]));

  // R6: a STOP releases the data line
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R11: a START releases the data line
  a_r11_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

endmodule

bind smb_regbank_slave smb_regbank_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lock_in   (lock_in),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_en     (wr_en),
  .regs_o    (regs_o)
);

// File: tb/tb_smb_regbank_slave.sv
`timescale 1ns/1ps
module tb_smb_regbank_slave;

  localparam int H = 6;
  localparam logic [7:0] WA = 8'hD2, RA = 8'hD3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, scl = 1'b1, m_low = 1'b0, addr_sel = 1'b0, lock_in = 1'b0;
  logic sda_oe;
  logic [71:0] regs;
  logic sda_line;
  assign sda_line = ~(m_low | sda_oe);

  smb_regbank_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_in(lock_in), .regs_o(regs)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic wire_bit(input logic b, output logic r);
    m_low = ~b; hp();
    scl = 1'b1; hp();
    r = sda_line;
    scl = 1'b0; hp();
  endtask

  task automatic do_start();
    m_low = 1'b0; hp();
    scl = 1'b1; hp();
    m_low = 1'b1; hp();
    scl = 1'b0; hp();
  endtask

  task automatic do_stop();
    m_low = 1'b1; hp();
    scl = 1'b1; hp();
    m_low = 1'b0; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) wire_bit(b[i], r);
    wire_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      wire_bit(1'b1, r);
      b[i] = r;
    end
    wire_bit(~give_ack, r);
  endtask

  task automatic byte_write(input logic [7:0] aw, input logic [7:0] off, input logic [7:0] d);
    logic a;
    do_start();
    send_byte(aw, a);  chk(a, "R10 address ack", a, 1);
    send_byte({1'b1, off[6:0]}, a); chk(a, "R10 command ack", a, 1);
    send_byte(d, a);   chk(a, "R10 data ack", a, 1);
    do_stop();
  endtask

  task automatic byte_read(input logic [7:0] off, output logic [7:0] d);
    logic a;
    do_start();
    send_byte(WA, a);
    send_byte({1'b1, off[6:0]}, a);
    do_start();
    send_byte(RA, a);
    recv_byte(d, 1'b0);
    do_stop();
  endtask

  // {kind(0 write,1 read), offset, data, expected}
  localparam logic [25:0] VEC [12] = '{
    {2'd1, 8'h01, 8'h00, 8'h2B},
    {2'd1, 8'h02, 8'h00, 8'h00},
    {2'd0, 8'h03, 8'hA5, 8'h00},
    {2'd1, 8'h03, 8'h00, 8'hA5},
    {2'd0, 8'h00, 8'hFF, 8'h00},
    {2'd1, 8'h00, 8'h00, 8'h7F},
    {2'd0, 8'h08, 8'h3C, 8'h00},
    {2'd1, 8'h08, 8'h00, 8'h3C},
    {2'd0, 8'h09, 8'h11, 8'h00},
    {2'd1, 8'h09, 8'h00, 8'hFF},
    {2'd0, 8'h7F, 8'h22, 8'h00},
    {2'd1, 8'h7F, 8'h00, 8'hFF}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic a, r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R8 defaults at reset
    chk(regs[6:0] == 7'h1F && regs[15:8] == 8'h2B && regs[71:16] == '0,
        "R8 reset defaults", regs[31:0], 32'h00002B1F);

    // table walk: R2 R3 R7 R9
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][25:24] == 2'd0) begin
        byte_write(WA, VEC[i][23:16], VEC[i][15:8]);
      end else begin
        byte_read(VEC[i][23:16], d);
        chk(d == VEC[i][7:0], $sformatf("R3 R7 R9 table row %0d", i), d, VEC[i][7:0]);
      end
    end
    chk(regs[71:64] == 8'h3C && regs[63:32] == 32'h0 && regs[31:24] == 8'hA5,
        "R2 R9 parallel view after table", regs[71:32], 32'h3C000000);

    // R7 live status
    lock_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(regs[7] == 1'b1, "R7 lock bit on parallel view", regs[7], 1);
    byte_read(8'h00, d);
    chk(d == 8'hFF, "R7 lock bit on read", d, 8'hFF);

    // R4 block write with count 04h
    do_start();
    send_byte(WA, a);
    send_byte(8'h00, a); chk(a, "R10 block command ack", a, 1);
    send_byte(8'h04, a); chk(a, "R10 count ack", a, 1);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    send_byte(8'h44, a);
    do_stop();
    chk(regs[31:0] == 32'h44332291, "R4 block write ascending", regs[31:0], 32'h44332291);

    // R5 block read
    do_start();
    send_byte(WA, a);
    send_byte(8'h00, a);
    do_start();
    send_byte(RA, a);
    recv_byte(d, 1'b1); chk(d == 8'h09, "R5 byte count", d, 8'h09);
    recv_byte(d, 1'b1); chk(d == 8'h91, "R5 block reg0", d, 8'h91);
    recv_byte(d, 1'b1); chk(d == 8'h22, "R5 block reg1", d, 8'h22);
    recv_byte(d, 1'b0); chk(d == 8'h33, "R5 block reg2", d, 8'h33);
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
    do_stop();

    // R6 STOP inside a block write
    do_start();
    send_byte(WA, a);
    send_byte(8'h00, a);
    send_byte(8'h09, a);
    send_byte(8'hAA, a);
    send_byte(8'hBB, a);
    wire_bit(1'b1, r); wire_bit(1'b1, r); wire_bit(1'b0, r);
    do_stop();
    chk(regs[23:8] == 16'h33BB && regs[6:0] == 7'h2A, "R6 partial block kept", regs[23:0], 24'h33BBAA);

    // R1 strap selects the other address
    addr_sel = 1'b1;
    do_start();
    send_byte(WA, a);
    chk(!a, "R1 old address refused", a, 0);
    do_stop();
    byte_write(8'hD4, 8'h05, 8'h5A);
    chk(regs[47:40] == 8'h5A, "R1 strapped address write", regs[47:40], 8'h5A);
    addr_sel = 1'b0;

    // R11 START in the middle of an address byte
    do_start();
    wire_bit(1'b1, r); wire_bit(1'b1, r); wire_bit(1'b0, r); wire_bit(1'b1, r);
    byte_write(WA, 8'h04, 8'h77);
    chk(regs[39:32] == 8'h77, "R11 restart mid byte", regs[39:32], 8'h77);

    // R8 reset again after traffic
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(regs[6:0] == 7'h1F && regs[15:8] == 8'h2B && regs[71:16] == '0,
        "R8 defaults restored", regs[31:0], 32'h00002B1F);

    finish_run();
  end

endmodule